// File: doc/BRIEF.md
# NOR flash command sequencer

This block models the command side of a parallel NOR flash in miniature. A small word array, reset to the erased value (all ones), is split into four equal banks. The block watches bus write cycles for unlock and command sequences. A complete sequence starts a timed internal word program. The block answers bus reads with either array contents or a status word, depending on which bank the read addresses.

A normal program takes four writes: two unlock writes, the program code, and the final write carrying target address and data. An unlock-bypass mode reduces this to two writes (program code, then address and data) until a two-write bypass exit is given. During an operation the addressed bank reports polling, toggle and error bits instead of data; the other banks keep returning array contents. A failed program leaves that bank in status mode until a read/reset code is written.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every array word reads 16'hFFFF, `ready` is 1 and the block is in normal (non-bypass) command mode; read data appears on `rd_data` on the clock after `rd_en` is sampled.
- R2: The writes AA@555h, 55@2AAh, A0@555h followed by a fourth write of (word address, data) start a program; `ready` is low for exactly PROG_CYCLES cycles beginning the cycle after the fourth write, and afterwards the word reads back the programmed result. Command codes are compared on `wdata[7:0]` and unlock addresses on `addr[11:0]`.
- R3: A program can only clear bits: the stored result is old AND new, and the operation fails when the new data has a 1 where the old word has a 0.
- R4: The writes AA@555h, 55@2AAh, 20@555h enter bypass mode; there a write of A0 (any address) followed by one write of (address, data) starts a program.
- R5: In bypass mode every write other than A0 or 90 is ignored, F0 included; 90 followed by 00 leaves bypass mode, after which a lone A0 no longer starts a program.
- R6: While a program runs, a read to the busy bank (bank = word address bits [7:6]) returns a status word: bit 7 is the inverse of data bit 7, bit 5 is 0, bits [15:8], [4:0] are 0, and bit 6 flips on each such status read.
- R7: A failed program latches an error: reads to that bank return status with bit 5 = 1 and bit 7 inverted, all writes except F0 are ignored, and F0 clears the error and returns to normal mode with array reads restored.
- R8: While a bank is busy or in error, reads to any other bank return array contents.
- R9: An F0 write, or any write not matching the expected step, inside an incomplete unlock sequence discards the partial sequence, so later stray command writes start nothing.
- R10: Writes issued while a program runs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Bus word address; low WORD_AW bits index the array |
| wdata | input | DATA_W | Bus write data or command code |
| rd_data | output | DATA_W | Registered read result (array word or status) |
| ready | output | 1 | High when no program is running |

## Verification
The assertions assume `wr_en` and `rd_en` are one-cycle strobes sampled at the rising edge, that reset is held for at least one edge before use, and that PROG_CYCLES is at least one. The stimulus drives every strobe for exactly one cycle from the falling edge and never asserts read and write together, so the toggle and command properties see one bus event per cycle. Reads of the busy bank are spaced two cycles apart and placed well inside the program window, so each status read falls while the operation is known to be running.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
    typedef enum logic [2:0] {
        C_IDLE,
        C_UNL1,
        C_UNL2,
        C_PROG,
        C_BPROG,
        C_BRST
    } cmd_st_e;

    localparam logic [7:0]  K_UNL1  = 8'hAA;
    localparam logic [7:0]  K_UNL2  = 8'h55;
    localparam logic [7:0]  K_PROG  = 8'hA0;
    localparam logic [7:0]  K_BYP   = 8'h20;
    localparam logic [7:0]  K_BRST1 = 8'h90;
    localparam logic [7:0]  K_BRST2 = 8'h00;
    localparam logic [7:0]  K_RESET = 8'hF0;
    localparam logic [11:0] ADR_A   = 12'h555;
    localparam logic [11:0] ADR_B   = 12'h2AA;
endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code,
    input  logic              busy,
    input  logic              err,
    output logic              start,
    output logic              clr_err
);
    typedef struct packed {
        cmd_st_e st;
        logic    byp;
    } dec_t;

    dec_t q, d;
    logic hit_a, hit_b;

    assign hit_a = (addr[11:0] == ADR_A);
    assign hit_b = (addr[11:0] == ADR_B);

    always_comb begin
        d       = q;
        start   = 1'b0;
        clr_err = 1'b0;
        if (wr_en && !busy) begin
            if (err) begin
                if (code == K_RESET) begin
                    clr_err = 1'b1;
                    d.st    = C_IDLE;
                    d.byp   = 1'b0;
                end
            end else begin
                case (q.st)
                    C_IDLE: begin
                        if (q.byp) begin
                            if (code == K_PROG)       d.st = C_BPROG;
                            else if (code == K_BRST1) d.st = C_BRST;
                        end else if (hit_a && code == K_UNL1) begin
                            d.st = C_UNL1;
                        end
                    end
                    C_UNL1: d.st = (hit_b && code == K_UNL2) ? C_UNL2 : C_IDLE;
                    C_UNL2: begin
                        if (hit_a && code == K_PROG) begin
                            d.st = C_PROG;
                        end else begin
                            d.st = C_IDLE;
                            if (hit_a && code == K_BYP) d.byp = 1'b1;
                        end
                    end
                    C_PROG, C_BPROG: begin
                        start = 1'b1;
                        d.st  = C_IDLE;
                    end
                    C_BRST: begin
                        d.st = C_IDLE;
                        if (code == K_BRST2) d.byp = 1'b0;
                    end
                    default: d.st = C_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= C_IDLE;
            q.byp <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R5: bypass mode is only left through a write
    a_r5_byp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.byp && !wr_en) |=> q.byp);
endmodule

// File: rtl/nor_prog_engine.sv
module nor_prog_engine #(
    parameter int WORD_AW     = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WORD_AW-1:0] st_addr,
    input  logic [DATA_W-1:0]  st_data,
    input  logic               clr_err,
    input  logic               stat_rd,
    input  logic [DATA_W-1:0]  old_word,
    output logic               busy,
    output logic               err,
    output logic               toggle,
    output logic [WORD_AW-1:0] tgt_addr,
    output logic               tgt_bit7,
    output logic               commit,
    output logic [DATA_W-1:0]  commit_data
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(PROG_CYCLES - 1);

    typedef struct packed {
        logic               busy;
        logic               err;
        logic               tog;
        logic [CW-1:0]      cnt;
        logic [WORD_AW-1:0] addr;
        logic [DATA_W-1:0]  data;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        commit = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_LOAD;
            d.addr = st_addr;
            d.data = st_data;
        end else if (q.busy && q.cnt == '0) begin
            commit = 1'b1;
            d.busy = 1'b0;
            d.err  = |(q.data & ~old_word);
        end else if (q.busy) begin
            d.cnt = q.cnt - 1'b1;
        end
        if (clr_err) d.err = 1'b0;
        if (stat_rd) d.tog = ~q.tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = q.busy;
    assign err         = q.err;
    assign toggle      = q.tog;
    assign tgt_addr    = q.addr;
    assign tgt_bit7    = q.data[7];
    assign commit_data = old_word & q.data;

    // R2: a running program cannot end before its counter expires
    a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != '0) |=> q.busy);
    // R7: the error flag only drops on a clear request
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !clr_err) |=> q.err);
    // R6: each status read flips the toggle bit
    a_r6_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (q.tog != $past(q.tog)));
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
    parameter int WORD_AW = 8,
    parameter int DATA_W  = 16,
    parameter int NBANK   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [WORD_AW-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [WORD_AW-1:0] raddr_a,
    output logic [DATA_W-1:0]  rdata_a,
    input  logic [WORD_AW-1:0] raddr_b,
    output logic [DATA_W-1:0]  rdata_b
);
    localparam int BW         = $clog2(NBANK);
    localparam int OW         = WORD_AW - BW;
    localparam int BANK_WORDS = 1 << OW;

    logic [DATA_W-1:0] rd_a_bank [NBANK];
    logic [DATA_W-1:0] rd_b_bank [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] mem [BANK_WORDS];
        logic              bank_we;

        assign bank_we = we && (waddr[WORD_AW-1 -: BW] == BW'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < BANK_WORDS; i++) mem[i] <= '1;
            end else if (bank_we) begin
                mem[waddr[OW-1:0]] <= wdata;
            end
        end

        assign rd_a_bank[b] = mem[raddr_a[OW-1:0]];
        assign rd_b_bank[b] = mem[raddr_b[OW-1:0]];

        // R3: a write into the array never turns a 0 into a 1
        a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            bank_we |-> ((wdata & ~mem[waddr[OW-1:0]]) == '0));
    end

    assign rdata_a = rd_a_bank[raddr_a[WORD_AW-1 -: BW]];
    assign rdata_b = rd_b_bank[raddr_b[WORD_AW-1 -: BW]];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
    parameter int ADDR_W      = 12,
    parameter int WORD_AW     = 8,
    parameter int DATA_W      = 16,
    parameter int NBANK       = 4,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);
    localparam int BW = $clog2(NBANK);

    logic               start, clr_err, busy, err, toggle, tgt_bit7, commit;
    logic               stat_sel, stat_rd;
    logic [WORD_AW-1:0] tgt_addr, word_a;
    logic [DATA_W-1:0]  arr_rd, old_word, commit_data, status_w;
    logic [DATA_W-1:0]  rd_d, rd_q;

    assign word_a = addr[WORD_AW-1:0];

    nor_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .code(wdata[7:0]), .busy(busy), .err(err),
        .start(start), .clr_err(clr_err)
    );

    nor_prog_engine #(
        .WORD_AW(WORD_AW), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .st_addr(word_a),
        .st_data(wdata), .clr_err(clr_err), .stat_rd(stat_rd),
        .old_word(old_word), .busy(busy), .err(err), .toggle(toggle),
        .tgt_addr(tgt_addr), .tgt_bit7(tgt_bit7), .commit(commit),
        .commit_data(commit_data)
    );

    nor_word_array #(
        .WORD_AW(WORD_AW), .DATA_W(DATA_W), .NBANK(NBANK)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(tgt_addr),
        .wdata(commit_data), .raddr_a(word_a), .rdata_a(arr_rd),
        .raddr_b(tgt_addr), .rdata_b(old_word)
    );

    always_comb begin
        stat_sel = (busy || err) &&
                   (word_a[WORD_AW-1 -: BW] == tgt_addr[WORD_AW-1 -: BW]);
        stat_rd  = rd_en && stat_sel;
        status_w    = '0;
        status_w[7] = ~tgt_bit7;
        status_w[6] = toggle;
        status_w[5] = err;
        rd_d = rd_q;
        if (rd_en) rd_d = stat_sel ? status_w : arr_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;
    assign ready   = ~busy;

    // R10: no program starts while one is running
    a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R7: no program starts while an error is latched
    a_r7_no_start_err: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !err);
endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nor_cmd_seq u_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic unlock;
        bus_wr(12'h555, 16'h00AA);
        bus_wr(12'h2AA, 16'h0055);
    endtask

    task automatic wait_ready;
        for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk(ready == 1'b1, "R1 ready after reset", 16'(ready), 16'h1);
        bus_rd(12'h010, v);
        chk(v == 16'hFFFF, "R1 erased word 0x10", v, 16'hFFFF);
        bus_rd(12'h0FF, v);
        chk(v == 16'hFFFF, "R1 erased word 0xFF", v, 16'hFFFF);
    endtask

    task automatic t_timing;
        logic [15:0] v;
        int n;
        unlock();
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h020, 16'hF00F);
        n = 0;
        while (!ready && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 16, "R2 ready low cycles", 16'(n), 16'd16);
        bus_rd(12'h020, v);
        chk(v == 16'hF00F, "R2 programmed word", v, 16'hF00F);
    endtask

    task automatic t_status;
        logic [15:0] v1, v2, v3;
        unlock();
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h040, 16'h1234);
        chk(ready == 1'b0, "R2 busy after fourth write", 16'(ready), 16'h0);
        bus_rd(12'h040, v1);
        bus_rd(12'h040, v2);
        chk((v1 & 16'hFFBF) == 16'h0080, "R6 polling word", v1, 16'h0080);
        chk(v1[6] != v2[6], "R6 toggle flips", v2, v1 ^ 16'h0040);
        bus_rd(12'h080, v3);
        chk(v3 == 16'hFFFF, "R8 other bank while busy", v3, 16'hFFFF);
        wait_ready();
        bus_rd(12'h040, v1);
        chk(v1 == 16'h1234, "R2 final data", v1, 16'h1234);
    endtask

    task automatic t_error;
        logic [15:0] v1, v2;
        unlock();
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h040, 16'h00FF);
        wait_ready();
        bus_rd(12'h040, v1);
        bus_rd(12'h040, v2);
        chk((v1 & 16'hFFBF) == 16'h0020, "R7 error status", v1, 16'h0020);
        chk((v2 & 16'hFFBF) == 16'h0020, "R7 error sticky", v2, 16'h0020);
        chk(v1[6] != v2[6], "R6 toggle during error", v2, v1 ^ 16'h0040);
        unlock();
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h080, 16'h0000);
        chk(ready == 1'b1, "R7 no program while error", 16'(ready), 16'h1);
        bus_rd(12'h080, v1);
        chk(v1 == 16'hFFFF, "R8 other bank during error", v1, 16'hFFFF);
        bus_wr(12'h000, 16'h00F0);
        bus_rd(12'h040, v1);
        chk(v1 == 16'h0034, "R3 result is old AND new", v1, 16'h0034);
    endtask

    task automatic t_abort;
        logic [15:0] v;
        bus_wr(12'h555, 16'h00AA);
        bus_wr(12'h000, 16'h00F0);
        bus_wr(12'h2AA, 16'h0055);
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h010, 16'h0000);
        chk(ready == 1'b1, "R9 reset after first unlock", 16'(ready), 16'h1);
        unlock();
        bus_wr(12'h000, 16'h00F0);
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h010, 16'h0000);
        chk(ready == 1'b1, "R9 reset after second unlock", 16'(ready), 16'h1);
        bus_wr(12'h555, 16'h00AA);
        bus_wr(12'h2AB, 16'h0055);
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h010, 16'h0000);
        bus_rd(12'h010, v);
        chk(v == 16'hFFFF, "R9 dropped sequences program nothing", v, 16'hFFFF);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] v;
        unlock();
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h011, 16'hAAAA);
        unlock();
        bus_wr(12'h555, 16'h00A0);
        bus_wr(12'h012, 16'h0000);
        wait_ready();
        bus_wr(12'h013, 16'h0000);
        chk(ready == 1'b1, "R10 no program after busy writes", 16'(ready), 16'h1);
        bus_rd(12'h012, v);
        chk(v == 16'hFFFF, "R10 write during busy ignored", v, 16'hFFFF);
        bus_rd(12'h011, v);
        chk(v == 16'hAAAA, "R10 first program intact", v, 16'hAAAA);
    endtask

    task automatic t_bypass;
        logic [15:0] v;
        unlock();
        bus_wr(12'h555, 16'h0020);
        bus_wr(12'h3C7, 16'h00A0);
        bus_wr(12'h0C0, 16'h00F0);
        chk(ready == 1'b0, "R4 two-write program starts", 16'(ready), 16'h0);
        wait_ready();
        bus_rd(12'h0C0, v);
        chk(v == 16'h00F0, "R4 bypass program data", v, 16'h00F0);
        bus_wr(12'h555, 16'h00AA);
        bus_wr(12'h0C2, 16'h5555);
        bus_wr(12'h000, 16'h00F0);
        chk(ready == 1'b1, "R5 stray writes start nothing", 16'(ready), 16'h1);
        bus_rd(12'h0C2, v);
        chk(v == 16'hFFFF, "R5 stray write ignored", v, 16'hFFFF);
        bus_wr(12'h000, 16'h00A0);
        bus_wr(12'h0C3, 16'h1111);
        wait_ready();
        bus_rd(12'h0C3, v);
        chk(v == 16'h1111, "R5 still in bypass after F0", v, 16'h1111);
        bus_wr(12'h000, 16'h0090);
        bus_wr(12'h000, 16'h0000);
        bus_wr(12'h000, 16'h00A0);
        bus_wr(12'h0C4, 16'h2222);
        chk(ready == 1'b1, "R5 bypass exited", 16'(ready), 16'h1);
        bus_rd(12'h0C4, v);
        chk(v == 16'hFFFF, "R5 lone A0 after exit", v, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_status();
        t_error();
        t_abort();
        t_busy_ignore();
        t_bypass();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule